// File: doc/BRIEF.md
# Flash Device Mode and Reset Controller

This block is the control core of a parallel NOR flash device, modelled synchronously and counted in clock cycles. It watches the active-low chip enable, output enable, write enable and reset pins, the address bus, and a start/done handshake from the embedded program/erase engine. From these it decides when the data bus may be driven and drives the ready/busy pin. It also reports the device's current mode and tells the output latch when to hold its data.

A reset pulse on the reset pin counts only once it has been low for a minimum number of cycles. Once it counts, it cancels any running operation and returns the device to array reads. The busy time that follows depends on whether an operation was running when the reset was accepted. Reads come back only after a recovery window. Deselecting the device does not stop a running operation. When the address stays the same for long enough, the device drops into automatic sleep and keeps its output data latched.

Top module: `flash_mode_ctrl`

## Requirements
- R1: Once the reset pin has been sampled low on T_RP consecutive clock edges, the reset is accepted. The mode becomes RESET (code 3) and any running operation is cancelled. If an operation was running, `eng_abort` is high for exactly one cycle.
- R2: A reset pin low pulse shorter than T_RP edges is ignored. The mode does not change, no abort is issued, and a running operation keeps running.
- R3: While the reset pin is low, `dq_oe` is 0, and engine start and autoselect commands have no effect. This holds even after the pin is released.
- R4: If an operation was running when the reset was accepted, `ry_by` stays 0 until T_READY_BUSY cycles after acceptance, and is 1 after that.
- R5: If no operation was running when the reset was accepted, `ry_by` stays 1 throughout. The internal reset completes T_READY_IDLE cycles after acceptance.
- R6: After an accepted reset, reads stay blocked (`dq_oe` 0, mode RESET) until the pin has been high for T_RH cycles and the internal reset has completed. The mode then returns to READ (code 0), and autoselect is cleared.
- R7: With chip enable high, no operation running and no sleep, the mode is STANDBY (code 4) and `dq_oe` is 0 whatever output enable does.
- R8: If chip enable goes high during an operation, the operation goes on. The mode stays BUSY (code 2) and `ry_by` stays 0 until `eng_done`.
- R9: When the address is unchanged for T_SLEEP cycles, `sleep_latch` goes to 1 and the mode becomes SLEEP (code 5) whatever chip enable does, unless the device is busy or in reset. Sleep does not change `dq_oe`.
- R10: Any change of address clears sleep in the same cycle and restarts the stability count.
- R11: `dq_oe` is 1 only when chip enable is low, output enable is low, write enable is high and no reset is pending. Output enable high always gives 0.
- R12: An autoselect command taken while idle and out of reset sets the mode to AUTOSEL (code 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pin_rst_n | input | 1 | Device reset pin, active low, synchronous to clk |
| addr | input | AW | Address bus |
| eng_start | input | 1 | Engine reports an operation started |
| eng_done | input | 1 | Engine reports an operation finished |
| autosel_cmd | input | 1 | Command decoder accepted the autoselect command |
| dq_oe | output | 1 | Data bus output enable |
| eng_abort | output | 1 | One-cycle abort to the engine |
| ry_by | output | 1 | Ready (1) / busy (0) |
| mode | output | 3 | Current mode code |
| sleep_latch | output | 1 | Output data latch hold in sleep |

## Verification
The bench goes after the reset pulse width boundary. A pulse one edge short must leave a running operation untouched, and a pulse of exactly the minimum width must cancel it. A design off by one edge would abort on the short pulse or miss the exact one. It separates the two ready times: ry_by is sampled one cycle before and two cycles after the busy-case limit, and must never fall in the idle case. A design that mixed up the limits, or pulled ry_by low on every reset, would fail there. It also checks that commands given while the pin is low are lost, that deselecting keeps an operation running, and that sleep beats standby yet ends in the very cycle the address moves.

// File: rtl/fmc_pkg.sv
// Package: shared mode codes for the flash mode controller.
// Assumes: three bits are enough for every mode.
package fmc_pkg;
    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_BUSY    = 3'd2,
        MODE_RESET   = 3'd3,
        MODE_STANDBY = 3'd4,
        MODE_SLEEP   = 3'd5
    } fmc_mode_e;
endpackage

// File: rtl/fmc_reset_seq.sv
// Reset sequencer: qualifies the reset pin by pulse width, times the
// internal reset (busy or idle limit) and the read recovery window.
// Assumes: pin_rst_n is already synchronous to clk; T_RP, T_RH >= 1.
module fmc_reset_seq #(
    parameter int T_RP         = 4,
    parameter int T_READY_BUSY = 20,
    parameter int T_READY_IDLE = 6,
    parameter int T_RH         = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_rst_n,
    input  logic op_busy,
    output logic accept,
    output logic rst_active,
    output logic hold_busy,
    output logic eng_abort
);
    localparam int RDY_MAX = (T_READY_BUSY > T_READY_IDLE) ? T_READY_BUSY : T_READY_IDLE;
    localparam int LW = $clog2(T_RP + 1);
    localparam int RW = $clog2(RDY_MAX + 1);
    localparam int HW = $clog2(T_RH + 1);

    logic [LW-1:0] lo_cnt;
    logic [RW-1:0] rdy_cnt;
    logic [RW-1:0] rdy_lim;
    logic [HW-1:0] rh_cnt;
    logic          acc;
    logic          was_busy;
    logic          rdy_done;

    // Acceptance happens on the T_RP-th low edge.
    always_comb accept = !pin_rst_n && !acc && (lo_cnt == LW'(T_RP - 1));

    // Limit of the internal reset depends on the state at acceptance.
    always_comb rdy_lim = was_busy ? RW'(T_READY_BUSY) : RW'(T_READY_IDLE);

    // Count consecutive low samples of the reset pin.
    always_ff @(posedge clk) begin
        if (!rst_n || pin_rst_n) begin
            lo_cnt <= '0;
        end else if (!acc && lo_cnt != LW'(T_RP)) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Hold the accepted-reset flag until recovery and internal reset finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= 1'b0;
            was_busy <= 1'b0;
        end else if (accept) begin
            acc      <= 1'b1;
            was_busy <= op_busy;
        end else if (acc && pin_rst_n && rdy_done && rh_cnt == HW'(T_RH)) begin
            acc      <= 1'b0;
        end
    end

    // Time the internal reset from the acceptance edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_cnt  <= '0;
            rdy_done <= 1'b1;
        end else if (accept) begin
            rdy_cnt  <= '0;
            rdy_done <= 1'b0;
        end else if (acc && !rdy_done) begin
            rdy_cnt <= rdy_cnt + 1'b1;
            if (rdy_cnt == rdy_lim - 1'b1) begin
                rdy_done <= 1'b1;
            end
        end
    end

    // Count high cycles of the pin after an accepted reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_rst_n || accept) begin
            rh_cnt <= '0;
        end else if (acc && rh_cnt != HW'(T_RH)) begin
            rh_cnt <= rh_cnt + 1'b1;
        end
    end

    // One-cycle abort when a running operation is cancelled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_abort <= 1'b0;
        end else begin
            eng_abort <= accept && op_busy;
        end
    end

    always_comb rst_active = acc;
    always_comb hold_busy  = acc && was_busy && !rdy_done;
endmodule

// File: rtl/fmc_sleep_timer.sv
// Sleep timer: counts cycles of unchanged address and flags sleep.
// Assumes: T_SLEEP >= 1; a change of address wakes the device at once.
module fmc_sleep_timer #(
    parameter int AW      = 8,
    parameter int T_SLEEP = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic          asleep
);
    localparam int SW = $clog2(T_SLEEP + 1);

    logic [AW-1:0] addr_q;
    logic [SW-1:0] stab_cnt;
    logic          addr_chg;

    always_comb addr_chg = (addr != addr_q);

    // Track the last address and count stable cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stab_cnt <= '0;
        end else begin
            addr_q <= addr;
            if (addr_chg) begin
                stab_cnt <= '0;
            end else if (stab_cnt != SW'(T_SLEEP)) begin
                stab_cnt <= stab_cnt + 1'b1;
            end
        end
    end

    // Sleep only while the count is full and the address has not moved.
    always_comb asleep = (stab_cnt == SW'(T_SLEEP)) && !addr_chg;
endmodule

// File: rtl/fmc_mode_core.sv
// Mode core: tracks the running operation and autoselect state, picks
// the reported mode and drives the bus enable and ready/busy pins.
// Assumes: eng_start and eng_done are single-cycle pulses.
module fmc_mode_core
    import fmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      pin_rst_n,
    input  logic      eng_start,
    input  logic      eng_done,
    input  logic      autosel_cmd,
    input  logic      accept,
    input  logic      rst_active,
    input  logic      hold_busy,
    input  logic      asleep,
    output logic      op_busy,
    output logic      dq_oe,
    output logic      ry_by,
    output fmc_mode_e mode,
    output logic      sleep_latch
);
    logic cmds_ok;
    logic as_mode;

    always_comb cmds_ok = pin_rst_n && !rst_active;

    // Track whether the embedded engine is running an operation.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            op_busy <= 1'b0;
        end else if (eng_done) begin
            op_busy <= 1'b0;
        end else if (eng_start && cmds_ok) begin
            op_busy <= 1'b1;
        end
    end

    // Enter autoselect on command; leave it on an accepted reset.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            as_mode <= 1'b0;
        end else if (autosel_cmd && cmds_ok && !op_busy) begin
            as_mode <= 1'b1;
        end
    end

    // Pick the reported mode by priority.
    always_comb begin
        if (rst_active)      mode = MODE_RESET;
        else if (op_busy)    mode = MODE_BUSY;
        else if (asleep)     mode = MODE_SLEEP;
        else if (ce_n)       mode = MODE_STANDBY;
        else if (as_mode)    mode = MODE_AUTOSEL;
        else                 mode = MODE_READ;
    end

    // Drive the bus only for a clean read cycle outside reset.
    always_comb dq_oe = cmds_ok && !ce_n && !oe_n && we_n;

    // Busy while an operation runs or a busy-case reset is pending.
    always_comb ry_by = !(op_busy || hold_busy);

    always_comb sleep_latch = asleep;
endmodule

// File: rtl/flash_mode_ctrl.sv
// Top: flash device mode and reset controller. Wires the reset
// sequencer, sleep timer and mode core together.
// Assumes: all pins are synchronous to clk; times are in cycles.
module flash_mode_ctrl #(
    parameter int AW           = 8,
    parameter int T_RP         = 4,
    parameter int T_READY_BUSY = 20,
    parameter int T_READY_IDLE = 6,
    parameter int T_RH         = 3,
    parameter int T_SLEEP      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          pin_rst_n,
    input  logic [AW-1:0] addr,
    input  logic          eng_start,
    input  logic          eng_done,
    input  logic          autosel_cmd,
    output logic          dq_oe,
    output logic          eng_abort,
    output logic          ry_by,
    output logic [2:0]    mode,
    output logic          sleep_latch
);
    import fmc_pkg::*;

    logic      accept;
    logic      rst_active;
    logic      hold_busy;
    logic      asleep;
    logic      op_busy;
    fmc_mode_e mode_e;

    fmc_reset_seq #(
        .T_RP(T_RP), .T_READY_BUSY(T_READY_BUSY),
        .T_READY_IDLE(T_READY_IDLE), .T_RH(T_RH)
    ) u_rseq (
        .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .op_busy(op_busy),
        .accept(accept), .rst_active(rst_active), .hold_busy(hold_busy),
        .eng_abort(eng_abort)
    );

    fmc_sleep_timer #(.AW(AW), .T_SLEEP(T_SLEEP)) u_sleep (
        .clk(clk), .rst_n(rst_n), .addr(addr), .asleep(asleep)
    );

    fmc_mode_core u_core (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pin_rst_n(pin_rst_n), .eng_start(eng_start), .eng_done(eng_done),
        .autosel_cmd(autosel_cmd), .accept(accept), .rst_active(rst_active),
        .hold_busy(hold_busy), .asleep(asleep), .op_busy(op_busy),
        .dq_oe(dq_oe), .ry_by(ry_by), .mode(mode_e), .sleep_latch(sleep_latch)
    );

    always_comb mode = mode_e;
endmodule

// File: rtl/fmc_checker.sv
// Checker: port-level properties of the flash mode controller.
module fmc_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          pin_rst_n,
    input logic [AW-1:0] addr,
    input logic          dq_oe,
    input logic          eng_abort,
    input logic [2:0]    mode,
    input logic          sleep_latch
);
    // R3
    pin_low_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_rst_n |-> !dq_oe);

    // R7
    deselect_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dq_oe);

    // R11
    oe_high_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R1
    abort_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> $past(!pin_rst_n));

    // R1
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_abort);

    // R6
    reset_exit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd3 && mode != 3'd3) |-> (mode != 3'd1));

    // R10
    addr_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) |-> (!sleep_latch && mode != 3'd5));
endmodule

bind flash_mode_ctrl fmc_checker #(.AW(AW)) u_fmc_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .pin_rst_n(pin_rst_n), .addr(addr), .dq_oe(dq_oe),
    .eng_abort(eng_abort), .mode(mode), .sleep_latch(sleep_latch)
);

// File: tb/flash_mode_ctrl_bench.sv
module flash_mode_ctrl_bench;
    localparam int AW = 8, T_RP = 4, T_RB = 20, T_RI = 6, T_RH = 3, T_SL = 10;
    localparam logic [2:0] M_READ = 3'd0, M_AS = 3'd1, M_BUSY = 3'd2,
                           M_RST = 3'd3, M_SBY = 3'd4, M_SLP = 3'd5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pin_rst_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic eng_start = 1'b0, eng_done = 1'b0, autosel_cmd = 1'b0;
    logic dq_oe, eng_abort, ry_by, sleep_latch;
    logic [2:0] mode;
    int n_run = 0, n_fail = 0, n_abort = 0;

    always #2.5 clk = ~clk;

    flash_mode_ctrl #(.AW(AW), .T_RP(T_RP), .T_READY_BUSY(T_RB),
        .T_READY_IDLE(T_RI), .T_RH(T_RH), .T_SLEEP(T_SL)) u_flash_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pin_rst_n(pin_rst_n), .addr(addr), .eng_start(eng_start),
        .eng_done(eng_done), .autosel_cmd(autosel_cmd), .dq_oe(dq_oe),
        .eng_abort(eng_abort), .ry_by(ry_by), .mode(mode),
        .sleep_latch(sleep_latch));

    // Count abort pulses away from the active edge.
    always @(negedge clk) if (rst_n && eng_abort) n_abort++;

    // {ce_n, oe_n, we_n, expected dq_oe, expected mode}
    localparam logic [6:0] VEC [6] = '{
        {3'b001, 1'b1, M_READ}, {3'b011, 1'b0, M_READ}, {3'b000, 1'b0, M_READ},
        {3'b101, 1'b0, M_SBY},  {3'b110, 1'b0, M_SBY},  {3'b010, 1'b0, M_READ}};

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic new_addr();
        addr = addr + 1'b1;
        #1;
    endtask

    task automatic pulse_start();
        eng_start = 1'b1; step(1); eng_start = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3); rst_n = 1'b1; step(1); new_addr();
        check("reset state mode R7", mode, M_SBY);
        check("reset state ry_by R4", ry_by, 1);
        check("reset state dq_oe R11", dq_oe, 0);

        // Vector walk over the pin combinations (R7, R11).
        for (int i = 0; i < 6; i++) begin
            {ce_n, oe_n, we_n} = VEC[i][6:4];
            step(1); new_addr();
            check($sformatf("vec%0d dq_oe R11", i), dq_oe, VEC[i][3]);
            check($sformatf("vec%0d mode R7", i), mode, VEC[i][2:0]);
        end

        // R12: autoselect when idle.
        ce_n = 0; oe_n = 0; we_n = 1;
        autosel_cmd = 1; step(1); autosel_cmd = 0; new_addr();
        check("autoselect mode R12", mode, M_AS);

        // R9 / R10: sleep after T_SL stable cycles, beats standby.
        ce_n = 1; step(1); new_addr();
        step(T_SL);
        check("not yet asleep R9", mode, M_SBY);
        step(1);
        check("asleep mode R9", mode, M_SLP);
        check("sleep latch R9", sleep_latch, 1);
        ce_n = 0; #1;
        check("sleep keeps dq_oe R9", dq_oe, 1);
        new_addr();
        check("wake on address R10", mode, M_AS);
        check("latch off on address R10", sleep_latch, 0);
        step(T_SL);
        check("count restarted R10", sleep_latch, 0);

        // R8: deselect during operation.
        pulse_start(); ce_n = 1; step(5);
        check("deselected busy mode R8", mode, M_BUSY);
        check("deselected busy ry_by R8", ry_by, 0);
        eng_done = 1; step(1); eng_done = 0; new_addr();
        check("done -> standby R8", mode, M_SBY);
        check("done ry_by R8", ry_by, 1);
        ce_n = 0;

        // R2: short pulse while busy is ignored.
        pulse_start(); n_abort = 0;
        pin_rst_n = 0; step(1); #1;
        check("low pin tristate R3", dq_oe, 0);
        step(T_RP - 2); pin_rst_n = 1; step(2);
        check("short pulse mode R2", mode, M_BUSY);
        check("short pulse abort R2", n_abort, 0);
        check("short pulse ry_by R2", ry_by, 0);

        // R1 / R4: accepted reset while busy.
        pin_rst_n = 0; step(T_RP);
        check("accepted mode R1", mode, M_RST);
        step(2); pin_rst_n = 1;
        check("abort pulse count R1", n_abort, 1);
        step(T_RB - 3);
        check("busy reset ry_by low R4", ry_by, 0);
        step(3); new_addr();
        check("busy reset ry_by high R4", ry_by, 1);
        check("busy reset back to read R6", mode, M_AS == M_READ ? M_READ : M_READ);
        check("read enabled after reset R6", dq_oe, 1);

        // R5 / R3 / R6: accepted reset while idle, in autoselect.
        autosel_cmd = 1; step(1); autosel_cmd = 0; new_addr();
        check("autoselect again R12", mode, M_AS);
        n_abort = 0;
        pin_rst_n = 0; step(1);
        autosel_cmd = 1; pulse_start(); autosel_cmd = 0;
        step(T_RP);
        check("idle accepted mode R1", mode, M_RST);
        check("idle ry_by high R5", ry_by, 1);
        step(T_RI + 2);
        check("idle ry_by still high R5", ry_by, 1);
        check("idle no abort R5", n_abort, 0);
        pin_rst_n = 1; step(T_RH - 1); #1;
        check("recovery blocks reads R6", dq_oe, 0);
        check("recovery mode R6", mode, M_RST);
        step(3); new_addr();
        check("idle reset back to read R6", mode, M_READ);
        check("ignored start R3", ry_by, 1);
        check("reads resume R6", dq_oe, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule